// File: doc/BRIEF.md
# Checkpointed Shadow Register File

This block is a register file meant for speculative execution of translated code blocks. Each architectural register is kept as a pair: a working copy, which ordinary instructions read and write, and a shadow copy, which holds the last known-good value. While a speculative block runs, all updates land in the working copies only. When the block finishes without trouble, a commit strobe copies every working register into its shadow in one clock edge. If something goes wrong, a rollback strobe copies every shadow back into the working set in one clock edge. The register state is then exactly what it was at the last commit, and the caller can re-run the code on a safe path.

The file has two combinational read ports and one write port. Reads always show the working copy. A write to the register being read is forwarded in the same cycle. The two strobes are level inputs sampled on the rising clock. When both are high, rollback takes precedence. Reset is synchronous and active-high, and it clears both copies.

Top module: `ckpt_regfile`

## Requirements
- R1: A synchronous reset clears every working copy and every shadow copy to zero. After reset, reads return 0, and a rollback with no prior commit also gives 0 on every register.
- R2: With `wr_en` high and `rollback` low, the working copy at `wr_addr` takes `wr_data` on the rising edge. Reads from the next cycle on return that value.
- R3: A write without a commit in the same cycle leaves all shadow copies unchanged.
- R4: With `commit` high and `rollback` low, every shadow copy takes the value of its working copy on that edge.
- R5: With `rollback` high, every working copy takes the value of its shadow copy on that edge, all registers at once.
- R6: With `commit` and `rollback` both high, the rollback is performed and the commit is ignored, so the shadow copies keep their old values.
- R7: A write in the same cycle as a commit, with no rollback, is included in the checkpoint. The shadow of `wr_addr` receives `wr_data`.
- R8: A write in the same cycle as a rollback is discarded. The target register holds its shadow value after the edge.
- R9: While an effective write is present (`wr_en` high, `rollback` low), a read port whose address equals `wr_addr` returns `wr_data` in the same cycle. During a rollback there is no forwarding, and the port shows the stored working value.
- R10: The two read ports select independently and can read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the working copy |
| wr_addr | input | ADDR_W | Register selected for the write |
| wr_data | input | DATA_W | Value to write |
| commit | input | 1 | Copy all working registers into their shadows |
| rollback | input | 1 | Restore all working registers from their shadows |
| rd_a_addr | input | ADDR_W | Read port A register select |
| rd_a_data | output | DATA_W | Read port A value (working copy, with forwarding) |
| rd_b_addr | input | ADDR_W | Read port B register select |
| rd_b_data | output | DATA_W | Read port B value (working copy, with forwarding) |

## Verification
The collisions that matter are a write landing in the same cycle as a checkpoint operation, and the two checkpoint strobes arriving together. Directed cycles are used to provoke each one: a write with commit, a write with rollback, and commit with rollback. Each is followed by a later rollback that exposes the shadow contents through the read ports. A behavioural model with a separate working array and shadow array predicts both read ports on every cycle. Random traffic then mixes all three operations at high rates.

// File: rtl/ckrf_pkg.sv
package ckrf_pkg;

    localparam int DEF_REGS  = 16;
    localparam int DEF_WIDTH = 32;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_COMMIT   = 2'd1,
        OP_ROLLBACK = 2'd2
    } ckpt_op_e;

    typedef struct packed {
        logic     write_ok;
        ckpt_op_e op;
    } ctrl_t;

    // Rollback has priority over commit.
    function automatic ckpt_op_e resolve_op(input logic do_commit, input logic do_rollback);
        if (do_rollback)
            return OP_ROLLBACK;
        else if (do_commit)
            return OP_COMMIT;
        return OP_NONE;
    endfunction

endpackage

// File: rtl/ckrf_ctrl.sv
module ckrf_ctrl
    import ckrf_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                commit,
    input  logic                rollback,
    output ctrl_t               ctrl,
    output logic [NUM_REGS-1:0] wr_sel
);

    always_comb begin
        ctrl.op       = resolve_op(commit, rollback);
        ctrl.write_ok = wr_en && (ctrl.op != OP_ROLLBACK);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign wr_sel[g] = ctrl.write_ok && (wr_addr == ADDR_W'(g));
    end

endmodule

// File: rtl/ckrf_cell.sv
module ckrf_cell
    import ckrf_pkg::*;
#(
    parameter int DATA_W = DEF_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  ckpt_op_e          op,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] work_q,
    output logic [DATA_W-1:0] shad_q
);

    logic [DATA_W-1:0] work_next;

    assign work_next = wr_hit ? wr_data : work_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            shad_q <= '0;
        end else begin
            unique case (op)
                OP_ROLLBACK: work_q <= shad_q;
                OP_COMMIT: begin
                    work_q <= work_next;
                    shad_q <= work_next;
                end
                default: work_q <= work_next;
            endcase
        end
    end

endmodule

// File: rtl/ckrf_rdport.sv
module ckrf_rdport
    import ckrf_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int DATA_W   = DEF_WIDTH,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0] work_arr,
    input  logic                           byp_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [DATA_W-1:0]              rd_data
);

    logic [DATA_W-1:0] stored;

    always_comb begin
        stored = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i))
                stored = work_arr[i];
        end
        rd_data = (byp_en && (rd_addr == wr_addr)) ? wr_data : stored;
    end

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
    import ckrf_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int DATA_W   = DEF_WIDTH,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit,
    input  logic              rollback,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    ctrl_t                       ctrl;
    logic [NUM_REGS-1:0]         wr_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] work_arr;
    logic [NUM_REGS-1:0][DATA_W-1:0] shad_arr;

    ckrf_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .commit   (commit),
        .rollback (rollback),
        .ctrl     (ctrl),
        .wr_sel   (wr_sel)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        ckrf_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .op      (ctrl.op),
            .wr_hit  (wr_sel[g]),
            .wr_data (wr_data),
            .work_q  (work_arr[g]),
            .shad_q  (shad_arr[g])
        );
    end

    ckrf_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
        .rd_addr  (rd_a_addr),
        .work_arr (work_arr),
        .byp_en   (ctrl.write_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_a_data)
    );

    ckrf_rdport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
        .rd_addr  (rd_b_addr),
        .work_arr (work_arr),
        .byp_en   (ctrl.write_ok),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_b_data)
    );

endmodule

// File: rtl/ckrf_checker.sv
module ckrf_checker #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [ADDR_W-1:0]               wr_addr,
    input logic [DATA_W-1:0]               wr_data,
    input logic                            commit,
    input logic                            rollback,
    input logic [ADDR_W-1:0]               rd_a_addr,
    input logic [DATA_W-1:0]               rd_a_data,
    input logic [NUM_REGS-1:0][DATA_W-1:0] work_arr,
    input logic [NUM_REGS-1:0][DATA_W-1:0] shad_arr
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (work_arr == '0 && shad_arr == '0));

    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> (shad_arr == $past(shad_arr)));

    p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (commit && !rollback && !wr_en) |=> (shad_arr == $past(work_arr)));

    p_restore_r5: assert property (@(posedge clk) disable iff (rst)
        rollback |=> (work_arr == $past(shad_arr)));

    p_rb_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (commit && rollback) |=> (shad_arr == $past(shad_arr)));

    p_commit_write_r7: assert property (@(posedge clk) disable iff (rst)
        (commit && !rollback && wr_en) |=> (shad_arr[$past(wr_addr)] == $past(wr_data)));

    p_drop_write_r8: assert property (@(posedge clk) disable iff (rst)
        (rollback && wr_en) |=> (work_arr[$past(wr_addr)] == $past(shad_arr[wr_addr])));

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rollback && rd_a_addr == wr_addr) |-> (rd_a_data == wr_data));

endmodule

bind ckpt_regfile ckrf_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .commit    (commit),
    .rollback  (rollback),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .work_arr  (work_arr),
    .shad_arr  (shad_arr)
);

// File: tb/tb_ckpt_regfile.sv
module tb_ckpt_regfile;

    localparam int NR = 16;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          commit = 1'b0;
    logic          rollback = 1'b0;
    logic [AW-1:0] rd_a_addr = '0;
    logic [AW-1:0] rd_b_addr = '0;
    logic [DW-1:0] rd_a_data;
    logic [DW-1:0] rd_b_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_work [NR];
    logic [DW-1:0] m_shad [NR];

    always #2.5 clk = ~clk;

    ckpt_regfile #(.NUM_REGS(NR), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .rollback(rollback),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
        if (!rst && wr_en && !rollback && wr_addr == a)
            return wr_data;
        return rst ? m_work[a] : m_work[a];
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: inputs applied at the falling edge, reads sampled 1 ns later,
    // model advanced at the rising edge.
    task automatic cyc(input bit we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input bit cm, input bit rb, input logic [AW-1:0] ra,
                       input logic [AW-1:0] rbad, input string tag);
        wr_en = we; wr_addr = wa; wr_data = wd;
        commit = cm; rollback = rb;
        rd_a_addr = ra; rd_b_addr = rbad;
        #1;
        if (!rst) begin
            check({tag, " portA"}, rd_a_data, expect_rd(ra));
            check({tag, " portB"}, rd_b_data, expect_rd(rbad));
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NR; i++) begin m_work[i] = '0; m_shad[i] = '0; end
        end else if (rb) begin
            for (int i = 0; i < NR; i++) m_work[i] = m_shad[i];
        end else begin
            if (we) m_work[wa] = wd;
            if (cm) for (int i = 0; i < NR; i++) m_shad[i] = m_work[i];
        end
        @(negedge clk);
    endtask

    task automatic idle_read(input logic [AW-1:0] ra, input logic [AW-1:0] rbad, input string tag);
        cyc(1'b0, '0, '0, 1'b0, 1'b0, ra, rbad, tag);
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < NR; i++)
            idle_read(AW'(i), AW'(NR - 1 - i), tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_work[i] = 'x; m_shad[i] = 'x; end
        @(negedge clk);
        rst = 1'b1;
        cyc(1'b1, 4'd3, 32'hdead_beef, 1'b0, 1'b0, '0, '0, "reset");
        cyc(1'b0, '0, '0, 1'b1, 1'b0, '0, '0, "reset");
        rst = 1'b0;

        // R1: working copies cleared, then shadows cleared (rollback without commit)
        read_all("R1 working zero");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, '0, '0, "R1 rollback");
        read_all("R1 shadow zero");
        for (int i = 0; i < NR; i++) check("R1 model", m_work[i], '0);

        // R2: writes land in working copy; R9 forwarding seen on same cycle
        for (int i = 0; i < NR; i++)
            cyc(1'b1, AW'(i), 32'h1000_0000 + 32'(i * 7), 1'b0, 1'b0, AW'(i), AW'((i + 1) % NR), "R9 bypass write");
        read_all("R2 readback");

        // R3/R5: no commit yet, rollback returns zeros everywhere
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 4'd2, 4'd5, "R5 rollback");
        read_all("R3 shadow untouched");

        // R4: write set, commit, overwrite, rollback restores committed set
        for (int i = 0; i < NR; i++)
            cyc(1'b1, AW'(i), 32'ha5a5_0000 ^ 32'(i << 4), 1'b0, 1'b0, AW'(i), '0, "R2 write");
        cyc(1'b0, '0, '0, 1'b1, 1'b0, '0, '0, "R4 commit");
        for (int i = 0; i < NR; i += 3)
            cyc(1'b1, AW'(i), 32'h5555_5555, 1'b0, 1'b0, AW'(i), AW'(i + 1), "R2 overwrite");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 4'd0, 4'd3, "R5 rollback");
        read_all("R4 committed restored");

        // R7: write in the commit cycle enters the checkpoint
        cyc(1'b1, 4'd7, 32'h7777_0007, 1'b1, 1'b0, 4'd7, 4'd6, "R7 write+commit");
        cyc(1'b1, 4'd7, 32'h0bad_0bad, 1'b0, 1'b0, 4'd7, 4'd7, "R7 overwrite");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 4'd7, 4'd7, "R7 rollback");
        idle_read(4'd7, 4'd6, "R7 shadow holds write");

        // R6: commit and rollback together -> rollback only, shadow kept
        cyc(1'b1, 4'd9, 32'h9999_9999, 1'b0, 1'b0, 4'd9, 4'd1, "R6 setup");
        cyc(1'b0, '0, '0, 1'b1, 1'b1, 4'd9, 4'd1, "R6 both");
        idle_read(4'd9, 4'd1, "R6 restored");
        cyc(1'b1, 4'd9, 32'h1234_5678, 1'b0, 1'b0, 4'd9, 4'd9, "R6 setup2");
        cyc(1'b0, '0, '0, 1'b0, 1'b1, 4'd9, 4'd9, "R6 rollback");
        idle_read(4'd9, 4'd0, "R6 shadow unchanged");

        // R8: write during rollback is dropped; R9 no forwarding in that cycle
        cyc(1'b1, 4'd4, 32'hfeed_f00d, 1'b0, 1'b1, 4'd4, 4'd4, "R8 R9 write+rollback");
        idle_read(4'd4, 4'd4, "R8 write discarded");

        // R10: independent ports across all address pairs
        for (int i = 0; i < NR; i++)
            idle_read(AW'(i), AW'((i * 5 + 3) % NR), "R10 two ports");

        // Mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            automatic logic [31:0] r = $urandom;
            cyc(r[0] | r[1], AW'(r[7:4]), $urandom, r[8] & r[9], r[10] & r[11] & r[12],
                AW'(r[19:16]), AW'(r[23:20]), "R2 R4 R5 random");
        end
        read_all("R5 final state");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule